// File: doc/BRIEF.md
# Serial Command Word Decoder

This block sits behind a byte-wide UART receiver. It turns a stream of received bytes into capture-control actions for a data acquisition front end. Bytes arrive with a one-cycle valid strobe, most significant byte first. An assembler state machine finds the two-byte sync pattern 0xAA, 0x55. It then collects a path byte and an opcode byte and hands the finished 32-bit word to a combinational decoder. A small control state machine keeps the capture enable level and produces one-cycle strobes for the reset command and for words it does not recognise.

A configuration input `net_sel` chooses which path byte is accepted: 0xEE when low, 0xFF when high. The opcodes are 0xA0 for start, 0xB1 for stop and 0xC1 for reset. A word is acted on in the clock cycle after the edge that accepted its fourth byte.

Assembler states:
- `ASM_HUNT` waits for 0xAA and moves to `ASM_SYNC_HI` when it arrives.
- `ASM_SYNC_HI` moves to `ASM_SYNC_LO` on 0x55. It stays where it is on another 0xAA and falls back to `ASM_HUNT` on any other byte.
- `ASM_SYNC_LO` takes the path byte and moves to `ASM_SELECT`.
- `ASM_SELECT` takes the opcode, marks the word complete and returns to `ASM_HUNT`.

Control states: `CAP_OFF` moves to `CAP_ON` on a start command. `CAP_ON` moves back to `CAP_OFF` on a stop command or a reset command.

Top module: `cmd_word_decoder`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `capture_en`, `reset_pulse` and `bad_word` are 0 and the assembler holds no partial word.
- R2: With `net_sel` low, the word 0xAA55EEA0 sets `capture_en` to 1.
- R3: With `net_sel` low, the word 0xAA55EEB1 clears `capture_en` to 0.
- R4: With `net_sel` low, the word 0xAA55EEC1 raises `reset_pulse` for exactly one cycle and clears `capture_en` in that same cycle.
- R5: With `net_sel` high, the path byte must be 0xFF. Start is 0xAA55FFA0, stop is 0xAA55FFB1 and reset is 0xAA55FFC1. Words that carry path byte 0xEE are then treated as unrecognised.
- R6: Bytes are taken most significant first. Outputs change only at the clock edge that follows the edge which accepted the fourth byte, and never after three bytes.
- R7: In the first byte position, any byte other than 0xAA is dropped. In the second position, a byte other than 0x55 restarts the search, and if that byte is 0xAA it counts as a new first byte.
- R8: A complete word whose path byte or opcode is not recognised leaves `capture_en` unchanged and raises `bad_word` for exactly one cycle.
- R9: A byte presented while `rx_valid` is low has no effect on the assembler or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| net_sel | input | 1 | Path byte select: 0 accepts 0xEE, 1 accepts 0xFF |
| capture_en | output | 1 | Capture enable level |
| reset_pulse | output | 1 | One-cycle pulse on a reset command |
| bad_word | output | 1 | One-cycle strobe on an unrecognised complete word |

## Verification
The checker watches the following on every cycle:
- the reset state;
- that the reset and error strobes last one cycle and never coincide;
- that the enable falls whenever a reset pulse fires;
- that the enable holds while an error strobe fires;
- that a rising enable is always preceded, two edges earlier, by an accepted byte.

Which word values act, and how the assembler recovers from a broken sync pattern, can only be shown by the bench. The bench feeds directed resync sequences and a random byte mix to a model of the protocol. It also shows that bytes presented with the strobe low are ignored and that `net_sel` selects the accepted path byte.

// File: rtl/cmdw_pkg.sv
package cmdw_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;

    localparam logic [BYTE_W-1:0] SYNC_HI_B   = 8'hAA;
    localparam logic [BYTE_W-1:0] SYNC_LO_B   = 8'h55;
    localparam logic [BYTE_W-1:0] PATH_SERIAL = 8'hEE;
    localparam logic [BYTE_W-1:0] PATH_NET    = 8'hFF;
    localparam logic [BYTE_W-1:0] OP_START    = 8'hA0;
    localparam logic [BYTE_W-1:0] OP_STOP     = 8'hB1;
    localparam logic [BYTE_W-1:0] OP_RESET    = 8'hC1;

    typedef enum logic [1:0] {
        ASM_HUNT,
        ASM_SYNC_HI,
        ASM_SYNC_LO,
        ASM_SELECT
    } asm_state_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_START,
        ACT_STOP,
        ACT_RESET,
        ACT_BAD
    } act_t;

    typedef enum logic {
        CAP_OFF,
        CAP_ON
    } cap_state_t;
endpackage

// File: rtl/cmdw_assembler.sv
module cmdw_assembler
    import cmdw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [WORD_W-1:0] word,
    output logic              word_vld
);
    asm_state_t state, state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ASM_HUNT;
        else     state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ASM_HUNT: begin
                if (rx_valid && rx_byte == SYNC_HI_B) state_nx = ASM_SYNC_HI;
            end
            ASM_SYNC_HI: begin
                if (rx_valid) begin
                    if (rx_byte == SYNC_LO_B)      state_nx = ASM_SYNC_LO;
                    else if (rx_byte == SYNC_HI_B) state_nx = ASM_SYNC_HI;
                    else                           state_nx = ASM_HUNT;
                end
            end
            ASM_SYNC_LO: begin
                if (rx_valid) state_nx = ASM_SELECT;
            end
            ASM_SELECT: begin
                if (rx_valid) state_nx = ASM_HUNT;
            end
        endcase
    end

    // Outputs: the last four accepted bytes, and a completion strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= rx_valid && (state == ASM_SELECT);
            if (rx_valid) word <= {word[WORD_W-BYTE_W-1:0], rx_byte};
        end
    end
endmodule

// File: rtl/cmdw_decode.sv
module cmdw_decode
    import cmdw_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              word_vld,
    input  logic              net_sel,
    output act_t              act
);
    localparam int OP_LO   = 0;
    localparam int PATH_LO = BYTE_W;
    localparam int SYNC_LO = 2 * BYTE_W;

    logic [BYTE_W-1:0]   path_want;
    logic [2*BYTE_W-1:0] sync_f;
    logic [BYTE_W-1:0]   path_f;
    logic [BYTE_W-1:0]   op_f;

    assign path_want = net_sel ? PATH_NET : PATH_SERIAL;
    assign sync_f    = word[SYNC_LO +: 2*BYTE_W];
    assign path_f    = word[PATH_LO +: BYTE_W];
    assign op_f      = word[OP_LO +: BYTE_W];

    always_comb begin
        act = ACT_NONE;
        if (word_vld) begin
            if (sync_f != {SYNC_HI_B, SYNC_LO_B} || path_f != path_want)
                act = ACT_BAD;
            else if (op_f == OP_START) act = ACT_START;
            else if (op_f == OP_STOP)  act = ACT_STOP;
            else if (op_f == OP_RESET) act = ACT_RESET;
            else                       act = ACT_BAD;
        end
    end
endmodule

// File: rtl/cmd_word_decoder.sv
module cmd_word_decoder
    import cmdw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       net_sel,
    output logic       capture_en,
    output logic       reset_pulse,
    output logic       bad_word
);
    logic [WORD_W-1:0] word;
    logic              word_vld;
    act_t              act;
    cap_state_t        cap, cap_nx;

    cmdw_assembler u_asm (
        .clk     (clk),
        .rst     (rst),
        .rx_valid(rx_valid),
        .rx_byte (rx_byte),
        .word    (word),
        .word_vld(word_vld)
    );

    cmdw_decode u_dec (
        .word    (word),
        .word_vld(word_vld),
        .net_sel (net_sel),
        .act     (act)
    );

    // Control state register
    always_ff @(posedge clk) begin
        if (rst) cap <= CAP_OFF;
        else     cap <= cap_nx;
    end

    always_comb begin
        cap_nx = cap;
        unique case (cap)
            CAP_OFF: if (act == ACT_START) cap_nx = CAP_ON;
            CAP_ON:  if (act == ACT_STOP || act == ACT_RESET) cap_nx = CAP_OFF;
        endcase
    end

    // Strobe outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            reset_pulse <= 1'b0;
            bad_word    <= 1'b0;
        end else begin
            reset_pulse <= (act == ACT_RESET);
            bad_word    <= (act == ACT_BAD);
        end
    end

    assign capture_en = (cap == CAP_ON);
endmodule

// File: rtl/cmdw_checker.sv
module cmdw_checker (
    input logic clk,
    input logic rst,
    input logic rx_valid,
    input logic capture_en,
    input logic reset_pulse,
    input logic bad_word
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!capture_en && !reset_pulse && !bad_word));

    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
        reset_pulse |=> !reset_pulse);

    assert_reset_clears_R4: assert property (@(posedge clk) disable iff (rst)
        reset_pulse |-> !capture_en);

    assert_bad_single_R8: assert property (@(posedge clk) disable iff (rst)
        bad_word |=> !bad_word);

    assert_bad_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (bad_word && !$past(rst)) |-> $stable(capture_en));

    assert_bad_not_reset_R8: assert property (@(posedge clk) disable iff (rst)
        !(bad_word && reset_pulse));

    assert_rise_after_byte_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(capture_en) |-> $past(rx_valid, 2));
endmodule

bind cmd_word_decoder cmdw_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .capture_en (capture_en),
    .reset_pulse(reset_pulse),
    .bad_word   (bad_word)
);

// File: tb/sim_cmd_word_decoder.sv
module sim_cmd_word_decoder;
    localparam time CLK_P = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       net_sel = 1'b0;
    logic       capture_en, reset_pulse, bad_word;

    int checks = 0;
    int errors = 0;

    // Bench model state
    int          m_pos = 0;
    logic [31:0] m_w = '0;
    logic        exp_cap = 1'b0, exp_rst = 1'b0, exp_bad = 1'b0;

    cmd_word_decoder u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .net_sel(net_sel), .capture_en(capture_en),
        .reset_pulse(reset_pulse), .bad_word(bad_word)
    );

    always #(CLK_P/2) clk = ~clk;

    // 0 none, 1 start, 2 stop, 3 reset, 4 unrecognised
    function automatic int expect_act(input logic [31:0] w, input logic net);
        if (w[31:16] != 16'hAA55 || w[15:8] != (net ? 8'hFF : 8'hEE)) return 4;
        case (w[7:0])
            8'hA0:   return 1;
            8'hB1:   return 2;
            8'hC1:   return 3;
            default: return 4;
        endcase
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model(input logic [7:0] b);
        int a;
        exp_rst = 1'b0;
        exp_bad = 1'b0;
        m_w = {m_w[23:0], b};
        case (m_pos)
            0: if (b == 8'hAA) m_pos = 1;
            1: m_pos = (b == 8'h55) ? 2 : ((b == 8'hAA) ? 1 : 0);
            2: m_pos = 3;
            default: begin
                m_pos = 0;
                a = expect_act(m_w, net_sel);
                if (a == 1) exp_cap = 1'b1;
                if (a == 2) exp_cap = 1'b0;
                if (a == 3) begin exp_cap = 1'b0; exp_rst = 1'b1; end
                if (a == 4) exp_bad = 1'b1;
            end
        endcase
    endtask

    // Drive one byte; return at the first negedge where its effect is visible
    task automatic push(input logic [7:0] b);
        model(b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0; rx_byte = $urandom();
        @(negedge clk);
    endtask

    task automatic push_word(input logic [31:0] w);
        for (int i = 3; i >= 0; i--) push(w[8*i +: 8]);
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " capture_en"}, capture_en, exp_cap);
        chk({tag, " reset_pulse"}, reset_pulse, exp_rst);
        chk({tag, " bad_word"}, bad_word, exp_bad);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int r;
        logic [7:0] pf, op;
        r = $urandom(32'd7606);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 capture_en", capture_en, 1'b0);
        chk("R1 reset_pulse", reset_pulse, 1'b0);
        chk("R1 bad_word", bad_word, 1'b0);

        // R6 and R2: no action after three bytes, start after four
        push(8'hAA); push(8'h55); push(8'hEE);
        chk("R6 no action after 3 bytes", capture_en, 1'b0);
        push(8'hA0);
        chk("R2 start sets enable", capture_en, 1'b1);

        // R3 stop
        push_word(32'hAA55EEB1);
        chk("R3 stop clears enable", capture_en, 1'b0);

        // R4 reset: one-cycle pulse, enable cleared
        push_word(32'hAA55EEA0);
        push_word(32'hAA55EEC1);
        chk("R4 reset pulse high", reset_pulse, 1'b1);
        chk("R4 reset clears enable", capture_en, 1'b0);
        @(negedge clk);
        chk("R4 reset pulse one cycle", reset_pulse, 1'b0);

        // R5 network path
        net_sel = 1'b1;
        push_word(32'hAA55EEA0);
        chk("R5 serial word rejected", bad_word, 1'b1);
        chk("R5 serial word no start", capture_en, 1'b0);
        push_word(32'hAA55FFA0);
        chk("R5 network start", capture_en, 1'b1);

        // R8 unknown opcode
        push_word(32'hAA55FF12);
        chk("R8 bad strobe", bad_word, 1'b1);
        chk("R8 enable unchanged", capture_en, 1'b1);
        @(negedge clk);
        chk("R8 bad strobe one cycle", bad_word, 1'b0);
        push_word(32'hAA55FFB1);
        chk("R5 network stop", capture_en, 1'b0);

        // R7 resynchronisation
        net_sel = 1'b0;
        push(8'hAA); push_word(32'hAA55EEA0);
        chk("R7 repeated AA resync", capture_en, 1'b1);
        push(8'h12); push_word(32'hAA55EEB1);
        chk("R7 junk first byte dropped", capture_en, 1'b0);
        chk("R7 no bad strobe", bad_word, 1'b0);
        push(8'hAA); push(8'h13); push_word(32'hAA55EEA0);
        chk("R7 second-byte mismatch restarts", capture_en, 1'b1);

        // R9 bytes with strobe low ignored
        push_word(32'hAA55EEB1);
        for (int i = 3; i >= 0; i--) begin
            @(negedge clk); rx_byte = 8'(32'hAA55EEA0 >> (8*i));
            @(negedge clk);
        end
        @(negedge clk);
        chk("R9 strobe-low bytes ignored", capture_en, 1'b0);
        chk("R9 no bad strobe", bad_word, 1'b0);
        push(8'hAA); push(8'h55); push(8'hEE); push(8'hA0);
        chk("R9 assembler empty afterwards", capture_en, 1'b1);

        // Random mix against the bench model (R2 R3 R4 R5 R6 R7 R8)
        for (int n = 0; n < 300; n++) begin
            if (m_pos == 0 && $urandom_range(0, 7) == 0) net_sel = ~net_sel;
            r = $urandom_range(0, 9);
            if (r < 5) begin
                case ($urandom_range(0, 2))
                    0: pf = 8'hEE;
                    1: pf = 8'hFF;
                    default: pf = 8'($urandom());
                endcase
                case ($urandom_range(0, 3))
                    0: op = 8'hA0;
                    1: op = 8'hB1;
                    2: op = 8'hC1;
                    default: op = 8'($urandom());
                endcase
                push(8'hAA); chk_all("R6 random");
                push(8'h55); chk_all("R6 random");
                push(pf);    chk_all("R5 random");
                push(op);    chk_all("R8 random");
            end else if (r < 7) begin
                push(8'hAA); chk_all("R7 random");
            end else begin
                push(8'($urandom())); chk_all("R7 random");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule